// File: doc/BRIEF.md
# Port Power Overcurrent Supervisor

This block drives the power-switch enables of three downstream host ports and cuts a port's power when an overcurrent persists. Each port's fault indication comes from one of two sources. In digital mode it is an active-low flag from an external power switch. In analog mode it is an active-high output from an on-chip comparator. One global mode bit picks the source for all ports at once. Ports that use dual-role operation need the analog setting, so the whole block then runs in analog mode.

Both fault sources are asynchronous, so each passes through a two-flop synchronizer. The selected source then feeds a per-port saturating counter. The counter rejects short in-rush pulses. A port trips only after its fault has stayed active for `TRIP_CYCLES` consecutive cycles. The default of 500,000 cycles is 10 ms at 50 MHz, which keeps cutoff well within a 15 ms ceiling.

A trip does two things: it turns the port's enable off, and it sets a sticky status bit for software. The port stays unpowered until software clears the status bit, drops the port's power request and then raises the request again. All pins are plain level or pulse signals: no data stream flows through the block, so there is no handshake.

Top module: `port_pwr_supervisor`

## Requirements
- R1: While reset is held and on the first cycles after it, every `pwr_en_n` bit is 1 (power off) and every `oc_status` bit is 0.
- R2: With no fault pending and no trip latched, `pwr_en_n[i]` equals the inverse of `pwr_req[i]`, one clock after `pwr_req[i]` changes.
- R3: In digital mode (`det_analog` = 0), `oc_flag_n[i]` = 0 means fault. A fault that reaches the filter for `TRIP_CYCLES` consecutive cycles trips port i. `oc_status[i]` becomes 1 and `pwr_en_n[i]` becomes 1 exactly `TRIP_CYCLES`+2 clock edges after the first edge that samples the fault; one edge earlier, neither has changed.
- R4: A fault held for `TRIP_CYCLES`-1 cycles does not trip the port. Any inactive cycle resets the filter count to zero, so two such pulses separated by a single inactive cycle do not trip either.
- R5: `oc_status[i]` stays 1 until a one-cycle pulse on `oc_clr[i]`, and is 0 from the clock after that pulse.
- R6: After a trip, `pwr_en_n[i]` stays 1 even when `pwr_req[i]` is held high and the status has been cleared. Power returns only after `pwr_req[i]` has been 0 with the status clear, and is then requested again.
- R7: In analog mode (`det_analog` = 1), `oc_cmp[i]` = 1 means fault and trips the port with the same filtering as R3, and `oc_flag_n` has no effect.
- R8: In digital mode, `oc_cmp` has no effect.
- R9: A trip on one port leaves the enables and status bits of the other ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| det_analog | input | 1 | Global detection select: 0 digital flag, 1 analog comparator |
| pwr_req | input | NUM_PORTS | Software power request per port, 1 = on |
| oc_clr | input | NUM_PORTS | One-cycle pulse per port that clears the sticky status |
| oc_flag_n | input | NUM_PORTS | Asynchronous active-low overcurrent flag from the external switch |
| oc_cmp | input | NUM_PORTS | Asynchronous active-high analog comparator output |
| pwr_en_n | output | NUM_PORTS | Active-low power-switch enable per port |
| oc_status | output | NUM_PORTS | Sticky overcurrent status per port |

## Verification
The embedded assertions check these properties on every cycle:
- the filter count never passes its limit and returns to zero on any inactive cycle;
- a filter trip is always followed one clock later by a set status bit and an off enable;
- the status never drops without a clear pulse;
- an enable is never on unless power was requested on the previous cycle, and never while the port is locked out.

Only the bench scenarios can show the following:
- the exact trip latency counted from the pin, and the one-cycle boundary between a rejected pulse and a trip;
- that the unused fault source is ignored in each mode;
- that the full re-arm sequence (clear, drop the request, raise it) brings power back.

// File: rtl/port_pwr_pkg.sv
package port_pwr_pkg;

  typedef enum logic {
    DET_DIGITAL = 1'b0,
    DET_ANALOG  = 1'b1
  } det_mode_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/ocs_sync.sv
module ocs_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      stab_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

endmodule

// File: rtl/ocs_filter.sv
module ocs_filter
  import port_pwr_pkg::*;
#(
  parameter int unsigned TRIP_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  output logic trip
);

  localparam int unsigned CW = cnt_width(TRIP_CYCLES);
  localparam logic [CW-1:0] LIMIT    = CW'(TRIP_CYCLES);
  localparam logic [CW-1:0] LAST_CNT = CW'(TRIP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // The trip fires once, on the cycle the run of faults reaches the limit.
  assign trip = fault && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!fault) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> (cnt_q == '0));

endmodule

// File: rtl/ocs_port_ctl.sv
module ocs_port_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic trip,
  input  logic clr,
  output logic pwr_on,
  output logic status
);

  logic status_q;
  logic lockout_q;
  logic pwr_on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (trip) begin
      status_q <= 1'b1;
    end else if (clr) begin
      status_q <= 1'b0;
    end
  end

  // The lockout is released only once the status is clear and the request is dropped.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lockout_q <= 1'b0;
    end else if (trip) begin
      lockout_q <= 1'b1;
    end else if (!status_q && !pwr_req) begin
      lockout_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_on_q <= 1'b0;
    end else begin
      pwr_on_q <= pwr_req && !trip && !status_q && !lockout_q;
    end
  end

  assign pwr_on = pwr_on_q;
  assign status = status_q;

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr) |=> status_q);

  // R6
  lockout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_q |=> !pwr_on_q);

  // R2
  on_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on_q |-> $past(pwr_req));

endmodule

// File: rtl/port_pwr_supervisor.sv
module port_pwr_supervisor
  import port_pwr_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned TRIP_CYCLES = 500000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 det_analog,
  input  logic [NUM_PORTS-1:0] pwr_req,
  input  logic [NUM_PORTS-1:0] oc_clr,
  input  logic [NUM_PORTS-1:0] oc_flag_n,
  input  logic [NUM_PORTS-1:0] oc_cmp,
  output logic [NUM_PORTS-1:0] pwr_en_n,
  output logic [NUM_PORTS-1:0] oc_status
);

  det_mode_e            mode;
  logic [NUM_PORTS-1:0] flag_n_s;
  logic [NUM_PORTS-1:0] cmp_s;
  logic [NUM_PORTS-1:0] fault;
  logic [NUM_PORTS-1:0] trip;
  logic [NUM_PORTS-1:0] pwr_on;

  assign mode = det_mode_e'(det_analog);

  ocs_sync #(.WIDTH(NUM_PORTS), .RST_VAL(1'b1)) flag_sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(oc_flag_n), .sync_out(flag_n_s)
  );

  ocs_sync #(.WIDTH(NUM_PORTS), .RST_VAL(1'b0)) cmp_sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(oc_cmp), .sync_out(cmp_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign fault[p] = (mode == DET_ANALOG) ? cmp_s[p] : !flag_n_s[p];

    ocs_filter #(.TRIP_CYCLES(TRIP_CYCLES)) filt_i (
      .clk(clk), .rst_n(rst_n), .fault(fault[p]), .trip(trip[p])
    );

    ocs_port_ctl ctl_i (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req[p]), .trip(trip[p]),
      .clr(oc_clr[p]), .pwr_on(pwr_on[p]), .status(oc_status[p])
    );

    assign pwr_en_n[p] = !pwr_on[p];

    // R3
    trip_cutoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip[p] |=> (oc_status[p] && pwr_en_n[p]));
  end

endmodule

// File: tb/port_pwr_supervisor_tb_top.sv
module port_pwr_supervisor_tb_top;

  localparam int unsigned NP   = 3;
  localparam int unsigned TRIP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          det_analog = 1'b0;
  logic [NP-1:0] pwr_req = '0;
  logic [NP-1:0] oc_clr = '0;
  logic [NP-1:0] oc_flag_n = '1;
  logic [NP-1:0] oc_cmp = '0;
  logic [NP-1:0] pwr_en_n;
  logic [NP-1:0] oc_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  port_pwr_supervisor #(.NUM_PORTS(NP), .TRIP_CYCLES(TRIP)) dut_i (
    .clk(clk), .rst_n(rst_n), .det_analog(det_analog), .pwr_req(pwr_req),
    .oc_clr(oc_clr), .oc_flag_n(oc_flag_n), .oc_cmp(oc_cmp),
    .pwr_en_n(pwr_en_n), .oc_status(oc_status)
  );

  typedef struct packed {
    logic [2:0] req;
    logic [2:0] flag_n;
    logic [2:0] cmp;
    logic       mode;
    logic [7:0] cycles;
    logic [2:0] exp_en_n;
    logic [2:0] exp_st;
  } vec_t;

  // Applied in order; state carries from one row to the next.
  localparam vec_t VECS [7] = '{
    '{3'b111, 3'b111, 3'b000, 1'b0, 8'd4,  3'b000, 3'b000}, // R2 all on
    '{3'b101, 3'b111, 3'b111, 1'b0, 8'd40, 3'b010, 3'b000}, // R8 comparator ignored
    '{3'b101, 3'b110, 3'b000, 1'b0, 8'd40, 3'b011, 3'b001}, // R3 R9 port0 trips
    '{3'b101, 3'b111, 3'b000, 1'b0, 8'd4,  3'b011, 3'b001}, // R5 still latched
    '{3'b100, 3'b111, 3'b000, 1'b1, 8'd4,  3'b011, 3'b001}, // mode switch, quiet
    '{3'b100, 3'b000, 3'b000, 1'b1, 8'd40, 3'b011, 3'b001}, // R7 flags ignored
    '{3'b100, 3'b111, 3'b100, 1'b1, 8'd40, 3'b111, 3'b101}  // R7 port2 trips
  };

  task automatic check(input string req, input string what,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    det_analog = 1'b0; pwr_req = '0; oc_clr = '0; oc_flag_n = '1; oc_cmp = '0;
    cycles(4);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    cycles(1);
    check("R1", "enables after reset", pwr_en_n, 3'b111);
    check("R1", "status after reset", oc_status, 3'b000);

    // Table walk
    for (int v = 0; v < 7; v++) begin
      pwr_req = VECS[v].req;
      oc_flag_n = VECS[v].flag_n;
      oc_cmp = VECS[v].cmp;
      det_analog = VECS[v].mode;
      cycles(int'(VECS[v].cycles));
      check("R2/R3/R5/R7/R8/R9", $sformatf("row %0d enables", v), pwr_en_n, VECS[v].exp_en_n);
      check("R3/R5/R7/R9", $sformatf("row %0d status", v), oc_status, VECS[v].exp_st);
    end

    // R5/R6: clear with requests low, then re-request
    pwr_req = '0; oc_cmp = '0;
    oc_clr = 3'b101; cycles(1); oc_clr = '0;
    cycles(1);
    check("R5", "status after clear", oc_status, 3'b000);
    cycles(2);
    pwr_req = 3'b111; cycles(2);
    check("R6", "power back after re-arm", pwr_en_n, 3'b000);

    // R6: clearing while the request stays high keeps the port off
    do_reset();
    pwr_req = 3'b111; cycles(3);
    oc_flag_n = 3'b101; cycles(TRIP + 6);
    oc_flag_n = 3'b111;
    check("R3", "port1 tripped", oc_status, 3'b010);
    oc_clr = 3'b010; cycles(1); oc_clr = '0; cycles(4);
    check("R6", "status cleared, request high", oc_status, 3'b000);
    check("R6", "still off with request held", pwr_en_n, 3'b010);
    pwr_req = 3'b101; cycles(3);
    pwr_req = 3'b111; cycles(2);
    check("R6", "on after request toggled", pwr_en_n, 3'b000);

    // R3: exact latency on port0
    do_reset();
    pwr_req = 3'b001; cycles(3);
    oc_flag_n = 3'b110;
    cycles(TRIP + 1);
    check("R3", "no trip one edge early", oc_status, 3'b000);
    check("R3", "enable on one edge early", pwr_en_n, 3'b110);
    cycles(1);
    check("R3", "trip at exact latency", oc_status, 3'b001);
    check("R3", "cutoff at exact latency", pwr_en_n, 3'b111);
    oc_flag_n = 3'b111;

    // R4: pulse one cycle short of the limit
    do_reset();
    pwr_req = 3'b001; cycles(3);
    oc_flag_n = 3'b110; cycles(TRIP - 1);
    oc_flag_n = 3'b111; cycles(30);
    check("R4", "short pulse rejected", oc_status, 3'b000);
    check("R4", "power kept after short pulse", pwr_en_n, 3'b110);

    // R4: two short pulses with one quiet cycle between them
    oc_flag_n = 3'b110; cycles(TRIP - 1);
    oc_flag_n = 3'b111; cycles(1);
    oc_flag_n = 3'b110; cycles(TRIP - 1);
    oc_flag_n = 3'b111; cycles(30);
    check("R4", "counter restarted", oc_status, 3'b000);

    // R7: analog trip at the same latency
    do_reset();
    det_analog = 1'b1; pwr_req = 3'b010; cycles(3);
    oc_cmp = 3'b010;
    cycles(TRIP + 1);
    check("R7", "analog no trip one edge early", oc_status, 3'b000);
    cycles(1);
    check("R7", "analog trip at latency", oc_status, 3'b010);
    check("R7", "analog cutoff", pwr_en_n, 3'b111);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule